// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps one processor's write-back cache coherent with its peers on a shared, atomic bus that uses invalidations. It has two faces. The processor side accepts one read or write at a time and completes cache hits in the same cycle. The bus side looks up every transaction placed on the bus by other agents. For each line it holds one of the four stable states: Modified, Exclusive, Shared or Invalid. While it waits for bus ownership, the pending request sits in one of three transient states: invalid-to-shared/exclusive, invalid-to-modified and shared-to-modified.

On a miss, or on a write to a Shared line, the controller raises a bus request and holds it. When the grant comes it places exactly one command on the bus. If the target index holds a different block in Modified, that command is a write-back of the victim. Otherwise it is a read, a read-for-ownership or an upgrade. The processor operation finishes in the grant cycle of that last command. Snooped transactions are still serviced while a request waits for the grant. A snooped ownership request for the block being upgraded cancels the local copy and turns the pending upgrade into a read-for-ownership. The tags and states exist twice, once for the processor side and once for the snoop side, so a snoop lookup takes a single cycle. Every state change writes both copies.

The cache is direct-mapped with one data word per block. The data store, the memory and the arbiter are reduced to plain ports. Bus command codes are: 0 = read, 1 = read-for-ownership, 2 = upgrade, 3 = write-back. A cache address splits into an index (its low `IDX_W` bits) and a tag (the remaining bits).

Top module: `mesiSnoopCtrl`

## Requirements
- R1: After reset every line is Invalid. `busReq`, `busCmdValid`, `cpuReady`, `snpDone`, `snpShared`, `snpDirty` and `flushValid` are all low.
- R2: A read hit in any valid state, and a write hit in Modified or Exclusive, raise `cpuReady` in the cycle the request is presented, with no bus request. A read hit returns the stored word on `cpuRdata`. A write hit in Exclusive silently makes the line Modified.
- R3: A read miss raises `busReq` from the next cycle and holds it until the grant. On the grant it drives command 0 with the request address. It completes with `busRdData` as the read data. The line then becomes Shared if `busSharedIn` was high in that cycle, and Exclusive otherwise.
- R4: A write hit in Shared raises `busReq` and leaves the line and its data untouched until the grant. On the grant it drives command 2 (upgrade), writes the data and makes the line Modified.
- R5: A write miss issues command 1 on the grant, fills the line with the write data and makes it Modified. A snooped command 1 or 2 to the same block while a shared-to-modified request is waiting invalidates the copy, and the grant then issues command 1 in place of command 2.
- R6: A snooped read on a Modified line flushes its word on `flushData` with `flushValid` and leaves the line Shared. A snooped read-for-ownership on a Modified line flushes it and leaves it Invalid. A snooped read on an Exclusive line makes it Shared without a flush. A snooped upgrade makes a Shared line Invalid.
- R7: The snoop result appears in the cycle after `snpValid`, marked by `snpDone`. `snpShared` reports a valid copy and `snpDirty` reports a Modified copy. When `snpDone` is low, all snoop outputs stay low.
- R8: Snooped transactions are looked up and acted on, including flushes, while a processor request waits for the grant.
- R9: A miss whose index holds a different block in Modified first issues command 3 on a grant, carrying the victim address and word, and invalidates the line. It keeps `busReq` high and issues its own command on a later grant.
- R10: `busCmdValid` is only driven during a cycle in which `busGrant` and `busReq` are both high. A write that obtains ownership finishes in that same grant cycle.
- R11: When a snoop arrives for the same index as a processor request in the same cycle, the processor request is held back that cycle (`cpuReady` low) and is then served against the post-snoop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor block address |
| cpuWdata | input | DATA_W | Write word |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read word, valid with `cpuReady` |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus granted this cycle |
| busCmdValid | output | 1 | A command is driven this cycle |
| busCmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| busAddr | output | ADDR_W | Command address |
| busWrData | output | DATA_W | Write-back word |
| busRdData | input | DATA_W | Fill word returned in the grant cycle |
| busSharedIn | input | 1 | Wired-OR shared line from the other caches during a read |
| snpValid | input | 1 | Another agent's transaction is on the bus |
| snpCmd | input | 2 | Snooped command code |
| snpAddr | input | ADDR_W | Snooped block address |
| snpDone | output | 1 | Snoop result valid |
| snpShared | output | 1 | Wired-OR contribution: copy held |
| snpDirty | output | 1 | Wired-OR contribution: copy modified |
| flushValid | output | 1 | Flushed word driven |
| flushData | output | DATA_W | Flushed word |

## Verification
The assertions take two facts about the environment as given. First, the atomic bus never grants this controller in a cycle where it also carries another agent's transaction. Second, the processor holds its request fields steady until `cpuReady`. They also assume that other agents never issue an upgrade for a block held here as Modified or Exclusive, and never a write-back for a block held here. The stimulus keeps to these rules: grants are applied only in cycles with no snoop, requests are held until completion, and each random snoop is checked for legality against the bench's own model of the line states, with an illegal pick replaced by a read.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPGR = 2'd2, CMD_WB = 2'd3} busCmd_t;
  typedef enum logic [1:0] {C_IDLE, C_IS_PEND, C_IM_PEND, C_SM_PEND} ctrlState_t;

  // Strobes from the processor-side control to the line store
  typedef struct packed {
    logic  lineWe;       // write the state of the request's line
    mesi_t lineState;    // state to write
    logic  tagWe;        // also load the request's tag
    logic  dataWe;       // write the data word
    logic  dataFromBus;  // 1: fill word, 0: processor word
  } procStrobe_t;
endpackage

// File: rtl/mesiSnoopRule.sv
module mesiSnoopRule
  import mesi_pkg::*;
(
  input  logic    hit,
  input  mesi_t   curState,
  input  busCmd_t cmd,
  output logic    stateWe,
  output mesi_t   nextState,
  output logic    flush
);
  always_comb begin
    stateWe   = 1'b0;
    nextState = curState;
    flush     = 1'b0;
    if (hit) begin
      unique case (cmd)
        CMD_RD: begin
          if (curState == ST_M || curState == ST_E) begin
            stateWe   = 1'b1;
            nextState = ST_S;
          end
          flush = (curState == ST_M);
        end
        CMD_RDX: begin
          stateWe   = 1'b1;
          nextState = ST_I;
          flush     = (curState == ST_M);
        end
        CMD_UPGR: begin
          stateWe   = 1'b1;
          nextState = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesiDatapath.sv
module mesiDatapath
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdData,
  input  procStrobe_t       strobe,
  input  logic              snpValid,
  input  busCmd_t           snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output mesi_t             procState,
  output logic              procTagMatch,
  output logic [ADDR_W-IDX_W-1:0] victimTag,
  output logic [DATA_W-1:0] lineData,
  output logic              snpDone,
  output logic              snpShared,
  output logic              snpDirty,
  output logic              flushValid,
  output logic [DATA_W-1:0] flushData
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  // Processor-side copy, snoop-side copy, shared data words
  logic [TAG_W-1:0]  tagP [LINES];
  logic [TAG_W-1:0]  tagS [LINES];
  mesi_t             stP  [LINES];
  mesi_t             stS  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // Processor-side lookup
  assign procState    = stP[cpuIdx];
  assign procTagMatch = (tagP[cpuIdx] == cpuTag);
  assign victimTag    = tagP[cpuIdx];
  assign lineData     = dataArr[cpuIdx];

  // Snoop-side lookup against the duplicated tags
  logic [LINES-1:0] snpHitVec;
  for (genvar g = 0; g < LINES; g++) begin : gSnpCmp
    assign snpHitVec[g] = (stS[g] != ST_I) && (tagS[g] == snpTag);
  end

  logic  snpHit, snpStateWe, snpFlush;
  mesi_t snpCur, snpNext;
  assign snpHit = snpValid && snpHitVec[snpIdx];
  assign snpCur = stS[snpIdx];

  mesiSnoopRule uRule (
    .hit      (snpHit),
    .curState (snpCur),
    .cmd      (snpCmd),
    .stateWe  (snpStateWe),
    .nextState(snpNext),
    .flush    (snpFlush)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stP[i]     <= ST_I;
        stS[i]     <= ST_I;
        tagP[i]    <= '0;
        tagS[i]    <= '0;
        dataArr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strobe.lineWe && cpuIdx == IDX_W'(i)) begin
          stP[i] <= strobe.lineState;
          stS[i] <= strobe.lineState;
          if (strobe.tagWe) begin
            tagP[i] <= cpuTag;
            tagS[i] <= cpuTag;
          end
        end
        if (strobe.dataWe && cpuIdx == IDX_W'(i))
          dataArr[i] <= strobe.dataFromBus ? busRdData : cpuWdata;
        // snoop update last: the bus order wins
        if (snpStateWe && snpIdx == IDX_W'(i)) begin
          stP[i] <= snpNext;
          stS[i] <= snpNext;
        end
      end
    end
  end

  // Registered snoop response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snpDone    <= 1'b0;
      snpShared  <= 1'b0;
      snpDirty   <= 1'b0;
      flushValid <= 1'b0;
      flushData  <= '0;
    end else begin
      snpDone    <= snpValid;
      snpShared  <= snpHit;
      snpDirty   <= snpHit && (snpCur == ST_M);
      flushValid <= snpFlush;
      flushData  <= snpFlush ? dataArr[snpIdx] : '0;
    end
  end
endmodule

// File: rtl/mesiControl.sv
module mesiControl
  import mesi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWrite,
  input  mesi_t       procState,
  input  logic        procTagMatch,
  input  logic        snpCollide,
  input  logic        snpRetarget,
  input  logic        busGrant,
  input  logic        busSharedIn,
  output procStrobe_t strobe,
  output logic        busReq,
  output logic        busCmdValid,
  output busCmd_t     busCmd,
  output logic        victimSel,
  output logic        cpuReady,
  output logic        rdataFromBus
);
  ctrlState_t state, stateNext;
  logic procHit, needWb;

  assign procHit = procTagMatch && (procState != ST_I);
  assign needWb  = (procState == ST_M) && !procTagMatch;

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    strobe.lineState = ST_I;
    busReq       = 1'b0;
    busCmdValid  = 1'b0;
    busCmd       = CMD_RD;
    victimSel    = 1'b0;
    cpuReady     = 1'b0;
    rdataFromBus = 1'b0;
    unique case (state)
      C_IDLE: begin
        if (cpuReq && !snpCollide) begin
          if (procHit) begin
            if (!cpuWrite) begin
              cpuReady = 1'b1;
            end else if (procState == ST_M || procState == ST_E) begin
              strobe.lineWe    = 1'b1;
              strobe.lineState = ST_M;
              strobe.dataWe    = 1'b1;
              cpuReady         = 1'b1;
            end else begin
              stateNext = C_SM_PEND;
            end
          end else begin
            stateNext = cpuWrite ? C_IM_PEND : C_IS_PEND;
          end
        end
      end
      default: begin
        busReq = 1'b1;
        if (state == C_SM_PEND && snpRetarget)
          stateNext = C_IM_PEND;
        if (busGrant) begin
          busCmdValid = 1'b1;
          if (needWb && state != C_SM_PEND) begin
            busCmd           = CMD_WB;
            victimSel        = 1'b1;
            strobe.lineWe    = 1'b1;
            strobe.lineState = ST_I;
          end else begin
            strobe.lineWe = 1'b1;
            strobe.dataWe = 1'b1;
            cpuReady      = 1'b1;
            stateNext     = C_IDLE;
            unique case (state)
              C_IS_PEND: begin
                busCmd             = CMD_RD;
                strobe.lineState   = busSharedIn ? ST_S : ST_E;
                strobe.tagWe       = 1'b1;
                strobe.dataFromBus = 1'b1;
                rdataFromBus       = 1'b1;
              end
              C_IM_PEND: begin
                busCmd           = CMD_RDX;
                strobe.lineState = ST_M;
                strobe.tagWe     = 1'b1;
              end
              default: begin
                busCmd           = CMD_UPGR;
                strobe.lineState = ST_M;
              end
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= C_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/mesiSnoopCtrl.sv
module mesiSnoopCtrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic              busCmdValid,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              busSharedIn,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpDone,
  output logic              snpShared,
  output logic              snpDirty,
  output logic              flushValid,
  output logic [DATA_W-1:0] flushData
);
  localparam int TAG_W = ADDR_W - IDX_W;

  procStrobe_t strobe;
  mesi_t       procState;
  logic        procTagMatch, victimSel, rdataFromBus;
  logic [TAG_W-1:0]  victimTag;
  logic [DATA_W-1:0] lineData;
  busCmd_t     cmdOut, snpCmdT;
  logic        snpCollide, snpRetarget;

  assign snpCmdT     = busCmd_t'(snpCmd);
  assign snpCollide  = snpValid && (snpAddr[IDX_W-1:0] == cpuAddr[IDX_W-1:0]);
  assign snpRetarget = snpValid && (snpAddr == cpuAddr) &&
                       (snpCmdT == CMD_RDX || snpCmdT == CMD_UPGR);

  mesiDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uPath (
    .clk, .rstN, .cpuAddr, .cpuWdata, .busRdData, .strobe,
    .snpValid, .snpCmd(snpCmdT), .snpAddr,
    .procState, .procTagMatch, .victimTag, .lineData,
    .snpDone, .snpShared, .snpDirty, .flushValid, .flushData
  );

  mesiControl uCtrl (
    .clk, .rstN, .cpuReq, .cpuWrite, .procState, .procTagMatch,
    .snpCollide, .snpRetarget, .busGrant, .busSharedIn,
    .strobe, .busReq, .busCmdValid, .busCmd(cmdOut), .victimSel,
    .cpuReady, .rdataFromBus
  );

  assign busCmd    = cmdOut;
  assign busAddr   = victimSel ? {victimTag, cpuAddr[IDX_W-1:0]} : cpuAddr;
  assign busWrData = victimSel ? lineData : '0;
  assign cpuRdata  = rdataFromBus ? busRdData : lineData;
endmodule

// File: rtl/mesiSnoopCtrl_chk.sv
module mesiSnoopCtrl_chk (
  input logic clk,
  input logic rstN,
  input logic cpuReq,
  input logic cpuReady,
  input logic busReq,
  input logic busGrant,
  input logic busCmdValid,
  input logic snpValid,
  input logic snpDone,
  input logic snpShared,
  input logic snpDirty,
  input logic flushValid
);
  assert_cmd_needs_grant_R10: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid |-> (busGrant && busReq));
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant) |=> busReq);
  assert_ready_has_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);
  assert_ready_free_of_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && !busGrant) |-> !busReq);
  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !snpDone |-> (!snpShared && !snpDirty && !flushValid));
  assert_dirty_implies_shared_R7: assert property (@(posedge clk) disable iff (!rstN)
    snpDirty |-> snpShared);
  assert_flush_is_dirty_R6: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> snpDirty);
  assert_snoop_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |=> snpDone);
  assert_snoop_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    !snpValid |=> !snpDone);
endmodule

bind mesiSnoopCtrl mesiSnoopCtrl_chk chk (.*);

// File: tb/tb_mesiSnoopCtrl.sv
module tb_mesiSnoopCtrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 2;
  localparam int LINES  = 1 << IDX_W;
  // state codes of the bench model
  localparam int MI = 0, MS = 1, ME = 2, MM = 3;
  localparam int RD = 0, RDX = 1, UPGR = 2, WB = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuReq = 0, cpuWrite = 0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic cpuReady;
  logic [DATA_W-1:0] cpuRdata;
  logic busReq, busGrant = 0, busCmdValid;
  logic [1:0] busCmd;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWrData, busRdData = '0;
  logic busSharedIn = 0, snpValid = 0;
  logic [1:0] snpCmd = '0;
  logic [ADDR_W-1:0] snpAddr = '0;
  logic snpDone, snpShared, snpDirty, flushValid;
  logic [DATA_W-1:0] flushData;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesiSnoopCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut (.*);

  int nChecks = 0, nFails = 0, cycles = 0;
  bit finished = 0;

  // bench model
  int mSt [LINES];
  logic [ADDR_W-IDX_W-1:0] mTag [LINES];
  logic [DATA_W-1:0] mData [LINES];
  bit pendActive = 0;
  int pendKind = RD;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int idxOf(logic [ADDR_W-1:0] a);
    return int'(a[IDX_W-1:0]);
  endfunction
  function automatic bit hitOf(logic [ADDR_W-1:0] a);
    return mSt[idxOf(a)] != MI && mTag[idxOf(a)] == a[ADDR_W-1:IDX_W];
  endfunction

  function automatic int snoopNext(int cur, int cmd);
    if (cmd == RD && (cur == MM || cur == ME)) return MS;
    if (cmd == RDX || cmd == UPGR) return MI;
    return cur;
  endfunction

  task automatic snoopOp(int cmd, logic [ADDR_W-1:0] a);
    bit h = hitOf(a);
    int cur = h ? mSt[idxOf(a)] : MI;
    snpValid = 1; snpCmd = 2'(cmd); snpAddr = a;
    if (pendActive && pendKind == UPGR && a == pendAddr && (cmd == RDX || cmd == UPGR))
      pendKind = RDX;
    @(posedge clk); @(negedge clk);
    chk("R7 done", snpDone, 1);
    chk("R7 shared", snpShared, h);
    chk("R7 dirty", snpDirty, cur == MM);
    chk("R6 flush", flushValid, cur == MM && (cmd == RD || cmd == RDX));
    if (cur == MM && (cmd == RD || cmd == RDX))
      chk("R6 flush data", flushData, mData[idxOf(a)]);
    if (pendActive) chk("R8 req held", busReq, 1);
    if (h) mSt[idxOf(a)] = snoopNext(cur, cmd);
    snpValid = 0;
  endtask

  task automatic opStart(bit w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    int i = idxOf(a);
    cpuReq = 1; cpuWrite = w; cpuAddr = a; cpuWdata = d;
    #1;
    if (hitOf(a) && (!w || mSt[i] != MS)) begin
      chk("R2 hit ready", cpuReady, 1);
      chk("R2 no bus", busReq, 0);
      if (!w) chk("R2 read data", cpuRdata, mData[i]);
      else begin mData[i] = d; mSt[i] = MM; end
      @(posedge clk); @(negedge clk);
      cpuReq = 0;
    end else begin
      chk("R3 miss not ready", cpuReady, 0);
      pendActive = 1; pendAddr = a; pendData = d;
      pendKind = !w ? RD : (hitOf(a) ? UPGR : RDX);
      @(posedge clk); @(negedge clk);
      chk("R3 request raised", busReq, 1);
    end
  endtask

  task automatic grantOp(bit sh, logic [DATA_W-1:0] rd);
    int i = idxOf(pendAddr);
    busGrant = 1; busSharedIn = sh; busRdData = rd;
    #1;
    chk("R10 cmd valid", busCmdValid, 1);
    if (mSt[i] == MM && mTag[i] != pendAddr[ADDR_W-1:IDX_W]) begin
      chk("R9 writeback cmd", busCmd, WB);
      chk("R9 victim addr", busAddr, {mTag[i], pendAddr[IDX_W-1:0]});
      chk("R9 victim data", busWrData, mData[i]);
      chk("R9 not ready", cpuReady, 0);
      mSt[i] = MI;
      @(posedge clk); @(negedge clk);
      busGrant = 0;
      chk("R9 request kept", busReq, 1);
    end else begin
      chk(pendKind == UPGR ? "R4 cmd" : (pendKind == RDX ? "R5 cmd" : "R3 cmd"), busCmd, pendKind);
      chk("R3 addr", busAddr, pendAddr);
      chk("R10 ready in grant", cpuReady, 1);
      if (pendKind == RD) begin
        chk("R3 read data", cpuRdata, rd);
        mSt[i] = sh ? MS : ME; mData[i] = rd;
      end else begin
        mSt[i] = MM; mData[i] = pendData;
      end
      mTag[i] = pendAddr[ADDR_W-1:IDX_W];
      @(posedge clk); @(negedge clk);
      busGrant = 0; cpuReq = 0; pendActive = 0;
      chk("R3 request dropped", busReq, 0);
    end
  endtask

  task automatic finishPending();
    while (pendActive) grantOp(1'($urandom_range(1)), $urandom);
  endtask

  function automatic logic [ADDR_W-1:0] rndAddr();
    return ADDR_W'({$urandom_range(3), 2'($urandom_range(LINES-1))});
  endfunction

  task automatic legalSnoop(logic [ADDR_W-1:0] a);
    int cmd = $urandom_range(3);
    int cur = hitOf(a) ? mSt[idxOf(a)] : MI;
    if (cmd == UPGR && !(cur == MI || cur == MS)) cmd = RD;
    if (cmd == WB && cur != MI) cmd = RD;
    snoopOp(cmd, a);
  endtask

  localparam logic [ADDR_W-1:0] A0 = 16'h0011; // idx1
  localparam logic [ADDR_W-1:0] B0 = 16'h0022; // idx2
  localparam logic [ADDR_W-1:0] C0 = 16'h0032; // idx2, other tag
  localparam logic [ADDR_W-1:0] D0 = 16'h0013; // idx3
  localparam logic [ADDR_W-1:0] E0 = 16'h0040; // idx0

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < LINES; i++) begin mSt[i] = MI; mTag[i] = '0; mData[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state
    chk("R1 busReq", busReq, 0);
    chk("R1 cpuReady", cpuReady, 0);
    chk("R1 cmdValid", busCmdValid, 0);
    chk("R1 snoop outputs", {snpDone, snpShared, snpDirty, flushValid}, 0);
    snoopOp(RD, A0); // R1: all lines invalid, no copy reported

    // R3 read miss -> E, R2 silent E->M, R6 flush on snooped read
    opStart(0, A0, 0);
    grantOp(0, 32'hAAAA_0001);
    opStart(1, A0, 32'h1111_2222);
    snoopOp(RD, A0);
    // R4 write in S waits; data untouched until grant
    opStart(1, A0, 32'h3333_4444);
    snoopOp(RD, A0);
    grantOp(0, 0);
    opStart(0, A0, 0);

    // R5 retarget of pending upgrade
    opStart(0, B0, 0);
    grantOp(1, 32'hBBBB_0002);
    opStart(1, B0, 32'h5555_6666);
    snoopOp(RDX, B0);
    chk("R5 retargeted", pendKind, RDX);
    grantOp(0, 0);

    // R9 victim write-back then read
    opStart(0, C0, 0);
    grantOp(0, 32'hCCCC_0003);
    grantOp(0, 32'hCCCC_0003);

    // R8 snoop flushes another line while pending
    opStart(0, D0, 0);
    snoopOp(RDX, A0);
    grantOp(1, 32'hDDDD_0004);

    // R7 idle cycle: outputs fall
    @(posedge clk); @(negedge clk);
    chk("R7 quiet", {snpDone, snpShared, snpDirty, flushValid}, 0);

    // R11 same-index snoop and processor hit collide
    opStart(0, E0, 0);
    grantOp(0, 32'hEEEE_0005);
    cpuReq = 1; cpuWrite = 1; cpuAddr = E0; cpuWdata = 32'h7777_8888;
    snpValid = 1; snpCmd = 2'(RDX); snpAddr = E0;
    #1;
    chk("R11 held back", cpuReady, 0);
    @(posedge clk); @(negedge clk);
    chk("R11 snoop shared", snpShared, 1);
    chk("R6 E not flushed", flushValid, 0);
    mSt[0] = MI; snpValid = 0;
    #1;
    chk("R11 now a miss", cpuReady, 0);
    pendActive = 1; pendAddr = E0; pendData = 32'h7777_8888; pendKind = RDX;
    @(posedge clk); @(negedge clk);
    chk("R11 request", busReq, 1);
    grantOp(0, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int pick = $urandom_range(3);
      if (pick < 2) begin
        opStart(1'($urandom_range(1)), rndAddr(), $urandom);
        if (pendActive) begin
          int ns = $urandom_range(2);
          for (int k = 0; k < ns; k++)
            legalSnoop(($urandom_range(1) == 1) ? pendAddr : rndAddr());
          finishPending();
        end
      end else begin
        legalSnoop(rndAddr());
      end
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule